// File: doc/BRIEF.md
# Complementary Input Pulse Qualifier

This block turns two complementary control lines into one clean gate command for a power-switch driver. One line is active high and the other active low. The command is asserted only when the active-high line is high and the active-low line is low. Each line first passes through a synchroniser. It then passes through its own width filter, so a level reaches the combining logic only after it has been held for a programmable number of clock cycles. Shorter glitches are discarded. Because both lines use the same filter, rising and falling command edges see the same delay, and the command keeps the width of a qualified input pulse.

A protection controller elsewhere in the chip can raise a mute request. While mute is high, the command is held low and both inputs are ignored. On release, each filter starts from the safe level again. The command therefore returns only after the inputs have qualified afresh.

Top module: `gate_cmd_qualifier`

## Requirements
- R1: While `rst` is high, `gate_cmd` is 0 at every clock edge, and it is still 0 in the first cycle after `rst` falls.
- R2: `gate_cmd` is 1 only when the qualified levels are `in_pos`=1 and `in_neg`=0. The combinations (0,0), (1,1) and (0,1) give 0.
- R3: The idle levels of the inputs are `in_pos`=0 and `in_neg`=1, and they give `gate_cmd`=0. Reset loads every synchroniser and filter stage with these levels.
- R4: A pulse on either input that lasts fewer than `QUAL_CYCLES` clock cycles produces no change on `gate_cmd`.
- R5: A level held on both inputs for at least `QUAL_CYCLES` cycles always reaches `gate_cmd`. A pulse of exactly `QUAL_CYCLES` cycles appears on `gate_cmd` with the same width.
- R6: Rising and falling command edges both take `SYNC_STAGES + QUAL_CYCLES + 1` clock edges from the input change to the change on `gate_cmd`.
- R7: When `mute` is sampled high at a clock edge, `gate_cmd` is 0 after that edge.
- R8: After `mute` falls, `gate_cmd` stays 0 for `QUAL_CYCLES` edges. With the inputs steady at (1,0), it rises after edge `QUAL_CYCLES + 1`.
- R9: Input activity that happens entirely while `mute` is high never appears on `gate_cmd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_pos | input | 1 | Active-high command input, asynchronous |
| in_neg | input | 1 | Active-low command input, asynchronous |
| mute | input | 1 | Synchronous override: forces the command low and clears both filters |
| gate_cmd | output | 1 | Qualified gate command, registered |

## Verification
A filter counter that holds a stale count would show at `gate_cmd` as a glitch being passed, or a valid edge arriving one or more cycles early or late. The reference model exposes either at the first clock compare after the expected edge. A filter that kept its state through `mute` would let the command return sooner than `QUAL_CYCLES + 1` edges after release, and the release check exposes this in that same window. A wrong safe level in a synchroniser or filter would give a wrong command right after reset or after a mute. The continuous per-cycle comparison flags that within the latency of the block.

// File: rtl/gq_pkg.sv
package gq_pkg;

    // Channel indices of the input pair.
    localparam int CH_POS = 0;
    localparam int CH_NEG = 1;
    localparam int NUM_CH = 2;

    // Level each channel takes when idle, after reset and during mute.
    localparam logic [NUM_CH-1:0] SAFE_LEVELS = 2'b10;

    typedef struct packed {
        logic neg;
        logic pos;
    } in_pair_t;

    function automatic in_pair_t to_pair(input logic [NUM_CH-1:0] v);
        in_pair_t p;
        p.pos = v[CH_POS];
        p.neg = v[CH_NEG];
        return p;
    endfunction

    // The command is on only for the active combination.
    function automatic logic combine(input in_pair_t p);
        return p.pos & ~p.neg;
    endfunction

endpackage

// File: rtl/gq_sync.sv
module gq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gq_width_filter.sv
module gq_width_filter #(
    parameter int   QUAL_CYCLES = 3,
    parameter logic SAFE_LEVEL  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic d,
    output logic lvl
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;

    // A new level is accepted once it has been seen on QUAL_CYCLES
    // consecutive samples; any return to the current level restarts the run.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lvl     <= SAFE_LEVEL;
            run_cnt <= '0;
        end else if (d == lvl) begin
            run_cnt <= '0;
        end else if (run_cnt == LIMIT) begin
            lvl     <= d;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gate_cmd_qualifier.sv
module gate_cmd_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_pos,
    input  logic in_neg,
    input  logic mute,
    output logic gate_cmd
);
    import gq_pkg::*;

    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] synced;
    logic [NUM_CH-1:0] qualified;
    in_pair_t          q_pair;
    logic              cmd_q;

    assign raw[CH_POS] = in_pos;
    assign raw[CH_NEG] = in_neg;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SAFE_LEVELS[ch])
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[ch]),
            .q   (synced[ch])
        );

        gq_width_filter #(
            .QUAL_CYCLES (QUAL_CYCLES),
            .SAFE_LEVEL  (SAFE_LEVELS[ch])
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .clear (mute),
            .d     (synced[ch]),
            .lvl   (qualified[ch])
        );
    end

    assign q_pair = to_pair(qualified);

    always_ff @(posedge clk) begin
        if (rst || mute) cmd_q <= 1'b0;
        else             cmd_q <= combine(q_pair);
    end

    assign gate_cmd = cmd_q;
endmodule

// File: rtl/gq_checker.sv
module gq_checker #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 3
) (
    input logic clk,
    input logic rst,
    input logic in_pos,
    input logic in_neg,
    input logic mute,
    input logic gate_cmd
);
    localparam int LAT   = SYNC_STAGES + QUAL_CYCLES + 1;
    localparam int RUN_W = $clog2(LAT + 1);
    localparam int REL   = QUAL_CYCLES + 1;
    localparam int REL_W = $clog2(REL + 1);

    logic [RUN_W-1:0] pos_lo_run, pos_hi_run, neg_lo_run, neg_hi_run;
    logic [REL_W-1:0] rel_cnt;

    function automatic logic [RUN_W-1:0] bump(input logic [RUN_W-1:0] v, input logic hit);
        if (!hit)                     return '0;
        else if (v == RUN_W'(LAT))    return v;
        else                          return v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_lo_run <= '0;
            pos_hi_run <= '0;
            neg_lo_run <= '0;
            neg_hi_run <= '0;
            rel_cnt    <= '0;
        end else begin
            pos_lo_run <= bump(pos_lo_run, !in_pos);
            pos_hi_run <= bump(pos_hi_run, in_pos);
            neg_lo_run <= bump(neg_lo_run, !in_neg);
            neg_hi_run <= bump(neg_hi_run, in_neg);
            if (mute)                     rel_cnt <= '0;
            else if (rel_cnt != REL_W'(REL)) rel_cnt <= rel_cnt + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !gate_cmd);

    // R2 / R3: a line resting at its idle level for a full latency keeps the command off
    assert_pos_idle_off_R2: assert property (@(posedge clk) disable iff (rst)
        (pos_lo_run == RUN_W'(LAT)) |-> !gate_cmd);

    assert_neg_idle_off_R3: assert property (@(posedge clk) disable iff (rst)
        (neg_hi_run == RUN_W'(LAT)) |-> !gate_cmd);

    assert_steady_on_R5: assert property (@(posedge clk) disable iff (rst)
        (pos_hi_run == RUN_W'(LAT) && neg_lo_run == RUN_W'(LAT) && rel_cnt == REL_W'(REL))
        |-> gate_cmd);

    assert_mute_forces_low_R7: assert property (@(posedge clk) disable iff (rst)
        mute |=> !gate_cmd);

    assert_release_hold_R8: assert property (@(posedge clk) disable iff (rst)
        gate_cmd |-> (rel_cnt == REL_W'(REL)));
endmodule

bind gate_cmd_qualifier gq_checker #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYCLES (QUAL_CYCLES)
) u_gq_checker (
    .clk      (clk),
    .rst      (rst),
    .in_pos   (in_pos),
    .in_neg   (in_neg),
    .mute     (mute),
    .gate_cmd (gate_cmd)
);

// File: tb/test_gate_cmd_qualifier.sv
module test_gate_cmd_qualifier;
    localparam int SYNC = 2;
    localparam int QUAL = 3;
    localparam int LAT  = SYNC + QUAL + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, in_pos = 1'b0, in_neg = 1'b1, mute = 1'b0;
    logic gate_cmd;

    int n_checks = 0;
    int n_fail   = 0;

    gate_cmd_qualifier #(.SYNC_STAGES(SYNC), .QUAL_CYCLES(QUAL)) i_gate_cmd_qualifier (
        .clk(clk), .rst(rst), .in_pos(in_pos), .in_neg(in_neg),
        .mute(mute), .gate_cmd(gate_cmd)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gate_cmd=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: value=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count cycles with the command high over a window.
    task automatic count_high(input int n, output int highs);
        highs = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate_cmd === 1'b1) highs++;
        end
    endtask

    // Behavioural reference: delay queues, a sliding sample window per line.
    bit qp[$], qn[$], hp[$], hn[$];
    bit lvl_p = 1'b0, lvl_n = 1'b1, exp_cmd = 1'b0;

    function automatic bit window_flips(input bit h[$], input bit lvl);
        if (h.size() != QUAL) return 1'b0;
        foreach (h[i]) if (h[i] == lvl) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        qp.delete(); qn.delete(); hp.delete(); hn.delete();
        repeat (SYNC) begin qp.push_back(1'b0); qn.push_back(1'b1); end
        lvl_p = 1'b0; lvl_n = 1'b1; exp_cmd = 1'b0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            exp_cmd = !mute && lvl_p && !lvl_n;
            if (mute) begin
                lvl_p = 1'b0; lvl_n = 1'b1; hp.delete(); hn.delete();
            end else begin
                hp.push_back(qp[SYNC-1]); if (hp.size() > QUAL) void'(hp.pop_front());
                hn.push_back(qn[SYNC-1]); if (hn.size() > QUAL) void'(hn.pop_front());
                if (window_flips(hp, lvl_p)) lvl_p = !lvl_p;
                if (window_flips(hn, lvl_n)) lvl_n = !lvl_n;
            end
            qp.push_front(in_pos); void'(qp.pop_back());
            qn.push_front(in_neg); void'(qn.pop_back());
        end
    end

    always @(negedge clk) check("model R2 R4 R6", gate_cmd, exp_cmd);

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int highs;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 after reset", gate_cmd, 1'b0);

        step(LAT + 2);
        check("R3 idle levels", gate_cmd, 1'b0);

        // R2 all combinations
        in_pos = 1'b1; in_neg = 1'b1; step(LAT + 2);
        check("R2 (1,1)", gate_cmd, 1'b0);
        in_pos = 1'b0; in_neg = 1'b0; step(LAT + 2);
        check("R2 (0,0)", gate_cmd, 1'b0);
        in_pos = 1'b1; in_neg = 1'b0; step(LAT + 2);
        check("R2 (1,0)", gate_cmd, 1'b1);
        in_pos = 1'b0; in_neg = 1'b1; step(LAT + 2);
        check("R2 (0,1)", gate_cmd, 1'b0);

        // R6 rising and falling latency
        in_pos = 1'b1; in_neg = 1'b0;
        step(LAT - 1); check("R6 rise early", gate_cmd, 1'b0);
        step(1);       check("R6 rise edge", gate_cmd, 1'b1);
        in_pos = 1'b0;
        step(LAT - 1); check("R6 fall early", gate_cmd, 1'b1);
        step(1);       check("R6 fall edge", gate_cmd, 1'b0);

        // R4 short pulse on in_pos while off
        step(LAT);
        in_pos = 1'b1; step(QUAL - 1); in_pos = 1'b0;
        count_high(2 * LAT, highs);
        check_int("R4 short pos pulse", highs, 0);

        // R4 short pulse on in_neg while on
        in_pos = 1'b1; step(LAT + 2);
        check("R5 steady on", gate_cmd, 1'b1);
        in_neg = 1'b1; step(QUAL - 1); in_neg = 1'b0;
        count_high(2 * LAT, highs);
        check_int("R4 short neg pulse", highs, 2 * LAT);

        // R5 pulse of exactly QUAL cycles keeps its width
        in_pos = 1'b0; step(LAT + 2);
        in_pos = 1'b1; step(QUAL); in_pos = 1'b0;
        count_high(2 * LAT, highs);
        check_int("R5 exact-width pulse", highs, QUAL);

        // R7 mute drops the command after one edge
        in_pos = 1'b1; step(LAT + 2);
        check("R5 on before mute", gate_cmd, 1'b1);
        mute = 1'b1; step(1);
        check("R7 mute", gate_cmd, 1'b0);

        // R9 activity during mute is ignored
        in_pos = 1'b0; step(5); in_pos = 1'b1; in_neg = 1'b1; step(QUAL + 2); in_neg = 1'b0;
        count_high(3 * LAT, highs);
        check_int("R9 inputs ignored while muted", highs, 0);

        // R8 release: requalification before the command returns
        mute = 1'b0;
        step(QUAL); check("R8 held after release", gate_cmd, 1'b0);
        step(1);    check("R8 return after release", gate_cmd, 1'b1);

        // R1 reset in mid-run
        rst = 1'b1; step(1);
        check("R1 reset in run", gate_cmd, 1'b0);
        rst = 1'b0; in_pos = 1'b0; in_neg = 1'b1; step(LAT);
        check("R1 after second reset", gate_cmd, 1'b0);

        finish_run();
    end
endmodule